// File: doc/BRIEF.md
# Video Memory Bus Arbitration Controller

This block sits between a CPU bus and the video subsystem. A CPU access to a fixed address window goes to one of three targets: the frame memory, the graphics memory, or a small bank of parameter registers for a block-copy engine. An 8-bit mode register decides which one. The mode register has a fixed address outside the window, and the CPU can reach it in every mode.

When the engage bit of the mode register is set, the CPU can reach neither memory. The window then holds the copy parameters, and a write to the slot just past them starts a copy. When the engage bit is clear, the CPU reads and writes the chosen memory directly and no copy can start.

The mode register also drives these outputs:
- the displayed frame page;
- the accessed frame page, which is independent of the displayed one;
- the graphics page;
- the completion-interrupt enable and the transparent-copy enable for the engine;
- a gate that passes the vertical-sync pulse to the CPU non-maskable interrupt line.

Top module: `vbus_arbiter`

## Requirements
- R1: After reset the mode register reads 0x00. With the register at 0x00, `fmem_cs`, `eng_start`, `nmi_out`, `disp_page` and `eng_enable` are low, and every parameter register is zero.
- R2: The mode register sits at `FLAG_ADDR` (default 0x2007). It can be written and read back whatever its own value is, and a write takes effect from the next clock.
- R3: With mode bit 0 clear and bit 5 set, a window access asserts `fmem_cs` only. `fmem_addr` is {bit 4, window offset}.
- R4: With mode bits 0 and 5 both clear, a window access asserts `gmem_cs` only. `gmem_addr` is {bit 3, window offset}.
- R5: With mode bit 0 set, neither memory select asserts. Writes to window offsets 0 to 5 land in parameter registers 0 to 5: destination X, destination Y, source X, source Y, width, height. These registers read back through the window and appear on `copy_params` at bits [8k+7:8k]. Reads at any other offset return 0.
- R6: A write to window offset 6 with bit 0 set raises `eng_start` for exactly one cycle, the cycle after the write. The same write with bit 0 clear goes to the selected memory and starts nothing.
- R7: `disp_page` follows mode bit 1 and does not depend on bit 4, the accessed frame page.
- R8: `nmi_out` is `vsync_in` gated by mode bit 2, as the register stood before any write in the same cycle.
- R9: `eng_enable`, `eng_irq_en` and `eng_transp` follow mode bits 0, 6 and 7.
- R10: An access that hits neither the window (default 0x4000 to 0x7FFF) nor `FLAG_ADDR` asserts no select and returns 0.
- R11: Window writes made while bit 0 is clear leave the parameter registers unchanged.
- R12: A read with bit 0 clear returns `fmem_rdata` or `gmem_rdata` for the selected memory. `mem_we` asserts for window writes to a memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| fmem_rdata | input | 8 | Frame memory read data |
| gmem_rdata | input | 8 | Graphics memory read data |
| fmem_cs | output | 1 | Frame memory select |
| gmem_cs | output | 1 | Graphics memory select |
| mem_we | output | 1 | Write enable to the selected memory |
| fmem_addr | output | 15 | Frame memory address: page bit and offset |
| gmem_addr | output | 15 | Graphics memory address: page bit and offset |
| vsync_in | input | 1 | Vertical-sync pulse from video timing |
| nmi_out | output | 1 | Non-maskable interrupt to the CPU |
| disp_page | output | 1 | Frame page sent to the display |
| eng_enable | output | 1 | Copy engine engaged |
| eng_irq_en | output | 1 | Completion interrupt enable |
| eng_transp | output | 1 | Transparent copy enable |
| eng_start | output | 1 | One-cycle copy start pulse |
| copy_params | output | 48 | Parameter registers, offset k at bits [8k+7:8k] |

## Verification
Two events can fall in the same clock cycle: a vertical-sync pulse and a CPU write that changes the interrupt gate. The bench drives `vsync_in` high in the very cycle that it writes the mode register to enable forwarding. It expects `nmi_out` low in that cycle and high in the next. It then makes the same collision with a write that clears the gate, and expects the pulse to pass in that cycle. The other case is a write to the start slot in a cycle where the engage bit is clear. That write must reach memory and must not start a copy.

// File: rtl/vbus_pkg.sv
package vbus_pkg;

  // Mode register bit positions
  localparam int FB_ENGAGE = 0;
  localparam int FB_DISP   = 1;
  localparam int FB_NMI    = 2;
  localparam int FB_GPAGE  = 3;
  localparam int FB_FPAGE  = 4;
  localparam int FB_FMEM   = 5;
  localparam int FB_IRQ    = 6;
  localparam int FB_TRANSP = 7;

  typedef enum logic [1:0] {
    RT_GFX   = 2'd0,
    RT_FRAME = 2'd1,
    RT_PARAM = 2'd2
  } route_e;

  // Window target chosen by the mode byte
  function automatic route_e route_of(input logic [7:0] mode);
    if (mode[FB_ENGAGE])    return RT_PARAM;
    else if (mode[FB_FMEM]) return RT_FRAME;
    else                    return RT_GFX;
  endfunction

endpackage

// File: rtl/vbus_decode.sv
module vbus_decode
  import vbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_AW = 14,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h4000,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'h2007,
  parameter int NUM_PARAMS = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [7:0]        mode,
  output logic              flag_hit,
  output logic              win_hit,
  output route_e            route,
  output logic [WIN_AW-1:0] offset,
  output logic              fmem_cs,
  output logic              gmem_cs,
  output logic              param_wr,
  output logic              start_hit
);

  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:WIN_AW] == WIN_BASE[ADDR_W-1:WIN_AW];
  endfunction

  logic access;

  always_comb begin
    access    = rd | wr;
    flag_hit  = access && (addr == FLAG_ADDR);
    win_hit   = access && in_window(addr);
    route     = route_of(mode);
    offset    = addr[WIN_AW-1:0];
    fmem_cs   = win_hit && (route == RT_FRAME);
    gmem_cs   = win_hit && (route == RT_GFX);
    param_wr  = wr && win_hit && (route == RT_PARAM);
    start_hit = param_wr && (offset == WIN_AW'(NUM_PARAMS));
  end

endmodule

// File: rtl/vbus_flags.sv
module vbus_flags
  import vbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       vsync_in,
  output logic [7:0] mode_q,
  output logic       nmi_out
);

  always_ff @(posedge clk) begin
    if (!rst_n)     mode_q <= '0;
    else if (wr_en) mode_q <= wdata;
  end

  // Gate uses the registered mode, so a same-cycle write acts one cycle later
  assign nmi_out = vsync_in & mode_q[FB_NMI];

endmodule

// File: rtl/vbus_params.sv
module vbus_params #(
  parameter int DATA_W     = 8,
  parameter int WIN_AW     = 14,
  parameter int NUM_PARAMS = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         start_hit,
  input  logic [WIN_AW-1:0]            offset,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  output logic [NUM_PARAMS*DATA_W-1:0] params_flat,
  output logic                         start_q
);

  logic [DATA_W-1:0] regs [NUM_PARAMS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_PARAMS; k++) regs[k] <= '0;
      start_q <= 1'b0;
    end else begin
      for (int k = 0; k < NUM_PARAMS; k++)
        if (wr_en && offset == WIN_AW'(k)) regs[k] <= wdata;
      start_q <= start_hit;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_PARAMS; k++)
      if (offset == WIN_AW'(k)) rdata = regs[k];
  end

  for (genvar g = 0; g < NUM_PARAMS; g++) begin : g_flat
    assign params_flat[g*DATA_W +: DATA_W] = regs[g];
  end

endmodule

// File: rtl/vbus_arbiter.sv
module vbus_arbiter
  import vbus_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int WIN_AW     = 14,
  parameter int NUM_PARAMS = 6,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h4000,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 16'h2007
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [DATA_W-1:0]            cpu_wdata,
  input  logic                         cpu_rd,
  input  logic                         cpu_wr,
  output logic [DATA_W-1:0]            cpu_rdata,
  input  logic [DATA_W-1:0]            fmem_rdata,
  input  logic [DATA_W-1:0]            gmem_rdata,
  output logic                         fmem_cs,
  output logic                         gmem_cs,
  output logic                         mem_we,
  output logic [WIN_AW:0]              fmem_addr,
  output logic [WIN_AW:0]              gmem_addr,
  input  logic                         vsync_in,
  output logic                         nmi_out,
  output logic                         disp_page,
  output logic                         eng_enable,
  output logic                         eng_irq_en,
  output logic                         eng_transp,
  output logic                         eng_start,
  output logic [NUM_PARAMS*DATA_W-1:0] copy_params
);

  // Named internal events, observed by the bound checker
  logic              flag_hit_w, win_hit_w, param_wr_w, start_hit_w, flag_wr_w;
  route_e            route_w;
  logic [WIN_AW-1:0] offset_w;
  logic [7:0]        mode_w;
  logic [DATA_W-1:0] param_rdata_w;

  vbus_decode #(
    .ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .WIN_BASE(WIN_BASE),
    .FLAG_ADDR(FLAG_ADDR), .NUM_PARAMS(NUM_PARAMS)
  ) u_decode (
    .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr), .mode(mode_w),
    .flag_hit(flag_hit_w), .win_hit(win_hit_w), .route(route_w),
    .offset(offset_w), .fmem_cs(fmem_cs), .gmem_cs(gmem_cs),
    .param_wr(param_wr_w), .start_hit(start_hit_w)
  );

  assign flag_wr_w = flag_hit_w & cpu_wr;

  vbus_flags u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(flag_wr_w), .wdata(cpu_wdata[7:0]),
    .vsync_in(vsync_in), .mode_q(mode_w), .nmi_out(nmi_out)
  );

  vbus_params #(
    .DATA_W(DATA_W), .WIN_AW(WIN_AW), .NUM_PARAMS(NUM_PARAMS)
  ) u_params (
    .clk(clk), .rst_n(rst_n), .wr_en(param_wr_w), .start_hit(start_hit_w),
    .offset(offset_w), .wdata(cpu_wdata), .rdata(param_rdata_w),
    .params_flat(copy_params), .start_q(eng_start)
  );

  assign mem_we     = cpu_wr & (fmem_cs | gmem_cs);
  assign fmem_addr  = {mode_w[FB_FPAGE], offset_w};
  assign gmem_addr  = {mode_w[FB_GPAGE], offset_w};
  assign disp_page  = mode_w[FB_DISP];
  assign eng_enable = mode_w[FB_ENGAGE];
  assign eng_irq_en = mode_w[FB_IRQ];
  assign eng_transp = mode_w[FB_TRANSP];

  always_comb begin
    cpu_rdata = '0;
    if (cpu_rd) begin
      if (flag_hit_w) cpu_rdata = DATA_W'(mode_w);
      else if (win_hit_w) begin
        unique case (route_w)
          RT_PARAM: cpu_rdata = param_rdata_w;
          RT_FRAME: cpu_rdata = fmem_rdata;
          default:  cpu_rdata = gmem_rdata;
        endcase
      end
    end
  end

endmodule

// File: rtl/vbus_arbiter_chk.sv
module vbus_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       eng_enable,
  input logic       fmem_cs,
  input logic       gmem_cs,
  input logic       eng_start,
  input logic       start_hit,
  input logic       nmi_out,
  input logic       vsync_in,
  input logic       flag_wr,
  input logic [7:0] mode_q
);

  // R5: no memory select while engaged
  assert_no_mem_engaged_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_enable |-> !(fmem_cs || gmem_cs));

  // R3 / R4: at most one memory selected
  assert_one_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fmem_cs, gmem_cs}));

  // R6: start pulse lasts one cycle
  assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  // R6: start pulse follows a start-slot write
  assert_start_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(start_hit));

  // R8: interrupt only during a sync pulse
  assert_nmi_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_out |-> vsync_in);

  // R2: mode register changes only on a write to it
  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> $stable(mode_q));

endmodule

bind vbus_arbiter vbus_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eng_enable(eng_enable), .fmem_cs(fmem_cs),
  .gmem_cs(gmem_cs), .eng_start(eng_start), .start_hit(start_hit_w),
  .nmi_out(nmi_out), .vsync_in(vsync_in), .flag_wr(flag_wr_w), .mode_q(mode_w)
);

// File: tb/test_vbus_arbiter.sv
module test_vbus_arbiter;

  localparam logic [15:0] FLAG = 16'h2007;
  localparam logic [15:0] WIN  = 16'h4000;
  localparam logic [7:0]  FDAT = 8'hA5;
  localparam logic [7:0]  GDAT = 8'h3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0, vsync_in = 1'b0;
  logic [7:0]  cpu_rdata;
  logic fmem_cs, gmem_cs, mem_we, nmi_out, disp_page;
  logic eng_enable, eng_irq_en, eng_transp, eng_start;
  logic [14:0] fmem_addr, gmem_addr;
  logic [47:0] copy_params;

  int checks = 0, failures = 0;
  logic s_f, s_g, s_we;

  always #5 clk = ~clk;

  vbus_arbiter i_vbus_arbiter (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .fmem_rdata(FDAT), .gmem_rdata(GDAT), .fmem_cs(fmem_cs), .gmem_cs(gmem_cs),
    .mem_we(mem_we), .fmem_addr(fmem_addr), .gmem_addr(gmem_addr),
    .vsync_in(vsync_in), .nmi_out(nmi_out), .disp_page(disp_page),
    .eng_enable(eng_enable), .eng_irq_en(eng_irq_en), .eng_transp(eng_transp),
    .eng_start(eng_start), .copy_params(copy_params)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    #2;
    s_f = fmem_cs; s_g = gmem_cs; s_we = mem_we;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #2;
    d = cpu_rdata; s_f = fmem_cs; s_g = gmem_cs;
    #1;
    cpu_rd = 1'b0;
  endtask

  // {mode, exp fmem_cs, exp gmem_cs, exp disp_page}
  localparam int NV = 6;
  localparam logic [10:0] VEC [NV] = '{
    {8'h20, 3'b100}, {8'h00, 3'b010}, {8'h32, 3'b101},
    {8'h08, 3'b010}, {8'h21, 3'b000}, {8'hC3, 3'b001}
  };

  initial begin
    #200000;
    checks++; failures++;
    $display("FAIL watchdog expired got=hang exp=done");
    summary();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 eng_start", eng_start, 0);
    chk("R1 nmi", nmi_out, 0);
    chk("R1 params", copy_params, 0);
    rd(FLAG, d); chk("R1 mode", d, 8'h00);
    chk("R1 fmem_cs at reset mode", s_f, 0);

    // Table walk: R3 R4 R5 R7 R9 R12
    for (int i = 0; i < NV; i++) begin
      logic [7:0] m;
      logic [7:0] expd;
      m = VEC[i][10:3];
      wr(FLAG, m);
      rd(WIN + 16'h0123, d);
      chk("R3 fmem_cs", s_f, VEC[i][2]);
      chk("R4 gmem_cs", s_g, VEC[i][1]);
      chk("R7 disp_page", disp_page, VEC[i][0]);
      chk("R3 fmem_addr", fmem_addr, {m[4], 14'h0123});
      chk("R4 gmem_addr", gmem_addr, {m[3], 14'h0123});
      chk("R9 engine bits", {eng_transp, eng_irq_en, eng_enable}, {m[7], m[6], m[0]});
      expd = VEC[i][2] ? FDAT : (VEC[i][1] ? GDAT : 8'h00);
      chk("R12 read data", d, expd);
      rd(FLAG, d); chk("R2 mode readback", d, m);
    end

    // R7 display page independent of accessed page
    wr(FLAG, 8'h10); chk("R7 disp with fpage=1", disp_page, 0);
    wr(FLAG, 8'h02); chk("R7 disp with fpage=0", disp_page, 1);

    // R11 disengaged window writes stay in memory
    wr(FLAG, 8'h20);
    wr(WIN + 16'h0000, 8'h77);
    chk("R12 mem_we", s_we, 1);
    chk("R12 fmem_cs write", s_f, 1);
    wr(FLAG, 8'h01);
    rd(WIN + 16'h0000, d); chk("R11 param untouched", d, 8'h00);

    // R5 parameter write and readback
    for (int k = 0; k < 6; k++) wr(WIN + 16'(k), 8'h11 * 8'(k + 1));
    chk("R5 mem_we engaged", s_we, 0);
    for (int k = 0; k < 6; k++) begin
      rd(WIN + 16'(k), d); chk("R5 param readback", d, 8'h11 * 8'(k + 1));
    end
    chk("R5 copy_params", copy_params, 48'h665544332211);
    rd(WIN + 16'h0007, d); chk("R5 unused offset", d, 8'h00);

    // R6 start pulse
    chk("R6 idle", eng_start, 0);
    wr(WIN + 16'h0006, 8'h00);
    chk("R6 pulse", eng_start, 1);
    @(negedge clk); chk("R6 pulse ends", eng_start, 0);

    // R6 disengaged start write goes to memory only
    wr(FLAG, 8'h00);
    wr(WIN + 16'h0006, 8'h55);
    chk("R6 no start when disengaged", eng_start, 0);
    chk("R6 write reached gmem", s_g, 1);

    // R10 outside window
    rd(16'h1000, d); chk("R10 rdata", d, 0); chk("R10 cs", {s_f, s_g}, 0);
    rd(16'h8000, d); chk("R10 rdata high", d, 0);

    // R8 vsync colliding with a mode write
    @(negedge clk);
    cpu_addr = FLAG; cpu_wdata = 8'h04; cpu_wr = 1'b1; vsync_in = 1'b1;
    #2 chk("R8 same-cycle enable", nmi_out, 0);
    @(negedge clk); cpu_wr = 1'b0;
    #2 chk("R8 enabled next cycle", nmi_out, 1);
    @(negedge clk);
    cpu_wdata = 8'h00; cpu_wr = 1'b1;
    #2 chk("R8 same-cycle disable", nmi_out, 1);
    @(negedge clk); cpu_wr = 1'b0;
    #2 chk("R8 disabled", nmi_out, 0);
    vsync_in = 1'b0;

    // R1 reset again clears state
    wr(FLAG, 8'hFF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(FLAG, d); chk("R1 mode after reset", d, 0);
    chk("R1 params after reset", copy_params, 0);

    summary();
  end

endmodule